// File: doc/BRIEF.md
# Edge-Detecting GPIO Controller

The block is a memory-mapped general-purpose I/O controller for up to 32 lines. Software reaches it through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Each line can be an input, or an output that drives a latched value. The read data of the line-state register shows the latch for output lines and the synchronized pin for input lines.

Every line has its own change detector. The pin passes through two synchronizing flops, and then the synchronized value is compared with its value one cycle earlier. A rising or a falling transition latches a sticky change bit. Software clears change bits by writing ones. A per-line enable decides which change bits reach the single interrupt output. A write-mask register limits which output latches a line-state write may touch. The number of implemented lines is set by a parameter. All unimplemented bit positions read as zero.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction, output latch, interrupt enable and change status are all zero, the write mask has every implemented bit set, and `irq` is low.
- R2: Register word offsets are: direction 0x00, line state 0x04, interrupt enable 0x08, change status 0x0C, write mask 0x10, trigger type 0x14. A direction bit of 1 makes the line an output (`pin_oe` high), and 0 makes it an input. Each register reads back what was written.
- R3: A write to the line-state register updates only the output-latch bits whose write-mask bit is 1. `pin_out` presents the latch.
- R4: Reading the line-state register returns the latch bit for output lines and the synchronized pin bit for input lines. A pin change first shows there after the second rising clock edge.
- R5: Any rising or falling pin transition sets that line's change bit after the third rising clock edge. This happens whether or not the line is enabled for interrupts.
- R6: Writing a 1 to a change-status bit clears that bit. Writing a 0 leaves it as it was.
- R7: If an edge reaches a change bit in the same cycle as a clearing write to that bit, the bit stays set.
- R8: `irq` is high exactly when at least one change bit is set whose interrupt-enable bit is also 1.
- R9: In the direction, line-state, enable, change and mask registers, bits at or above `NUM_LINES` read as zero and ignore writes.
- R10: The trigger-type register always reads 0x0000_0003 (bit 0 means rising edges, bit 1 means falling edges) and ignores writes.
- R11: Addresses with no register behind them read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_LINES | Asynchronous pin levels |
| pin_out | output | NUM_LINES | Output latch values |
| pin_oe | output | NUM_LINES | Output enables (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the controller with `NUM_LINES` = 12, so that twenty unimplemented bit positions exist. Their read-as-zero and write-ignore behaviour can then be checked in every register. With the default `ADDR_W` of 8, offsets past the trigger-type register are decodable, which lets the bench check the unmapped-address behaviour. At this width, random direction, mask and pin patterns cover mixed input/output lines and partial masks within a few hundred operations. Directed cases pin down the two-edge and three-edge latencies and the same-cycle collision of an edge with a clearing write.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

  // word indices (byte offset / 4)
  localparam int IDX_DIR  = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_IEN  = 2;
  localparam int IDX_CHG  = 3;
  localparam int IDX_MASK = 4;
  localparam int IDX_TYPE = 5;

  // bit0: rising edges detected, bit1: falling edges detected
  localparam logic [31:0] TRIG_BOTH_CODE = 32'h0000_0003;

  function automatic logic [31:0] merge_masked(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [31:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic [31:0] line_view(input logic [31:0] dir,
                                            input logic [31:0] latch,
                                            input logic [31:0] pins);
    return (dir & latch) | (~dir & pins);
  endfunction

  function automatic logic [31:0] status_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] hit);
    return (cur & ~clr) | hit;
  endfunction

endpackage

// File: rtl/gpio_line_sync.sv
`timescale 1ns/1ps
module gpio_line_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] edge_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[i] = sync_q;
    assign edge_o[i] = sync_q ^ prev_q;
  end

  // an edge flag is only raised when the synchronized value just moved (R5)
  assert_edge_means_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o != '0) |-> ((sync_o ^ $past(sync_o)) & edge_o) == edge_o);

endmodule

// File: rtl/gpio_change_status.sv
`timescale 1ns/1ps
module gpio_change_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] chg_o
);
  import gpio_edge_pkg::*;

  logic [31:0] cur32, clr32, hit32, nxt32;

  always_comb begin
    cur32 = '0; clr32 = '0; hit32 = '0;
    cur32[WIDTH-1:0] = chg_o;
    clr32[WIDTH-1:0] = clr_i;
    hit32[WIDTH-1:0] = edge_i;
    nxt32 = status_next(cur32, clr32, hit32);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg_o <= '0;
    else        chg_o <= nxt32[WIDTH-1:0];
  end

  // every edge latches its bit, collisions included (R5, R7)
  assert_edge_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i != '0) |=> (chg_o & $past(edge_i)) == $past(edge_i));
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_i & clr_i) != '0) |=> (chg_o & $past(edge_i & clr_i)) != '0);
  // cleared bits without a concurrent edge go to zero (R6)
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> (chg_o & $past(clr_i & ~edge_i)) == '0);
  // no edge and no clear: status holds (R6)
  assert_status_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i == '0 && clr_i == '0) |=> $stable(chg_o));

endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  import gpio_edge_pkg::*;

  localparam int W     = NUM_LINES;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [31:0] LINE_MASK32 = 32'((64'd1 << W) - 64'd1);

  if (W < 1 || W > 32 || ADDR_W < 5) begin : g_bad_cfg
    $error("gpio_edge_ctrl: NUM_LINES must be 1..32 and ADDR_W at least 5");
  end

  function automatic logic [31:0] widen(input logic [W-1:0] v);
    logic [31:0] r;
    r = '0;
    r[W-1:0] = v;
    return r;
  endfunction

  // decode
  logic [IDX_W-1:0] word_idx;
  logic sel_dir, sel_data, sel_ien, sel_chg, sel_mask, sel_type;
  assign word_idx = bus_addr[ADDR_W-1:2];
  assign sel_dir  = (word_idx == IDX_W'(IDX_DIR));
  assign sel_data = (word_idx == IDX_W'(IDX_DATA));
  assign sel_ien  = (word_idx == IDX_W'(IDX_IEN));
  assign sel_chg  = (word_idx == IDX_W'(IDX_CHG));
  assign sel_mask = (word_idx == IDX_W'(IDX_MASK));
  assign sel_type = (word_idx == IDX_W'(IDX_TYPE));

  logic wr_dir, wr_data, wr_ien, wr_mask;
  assign wr_dir  = bus_we && sel_dir;
  assign wr_data = bus_we && sel_data;
  assign wr_ien  = bus_we && sel_ien;
  assign wr_mask = bus_we && sel_mask;

  logic [W-1:0] wdata_w;
  assign wdata_w = bus_wdata[W-1:0];

  // registers
  logic [W-1:0] dir_q, out_q, ien_q, mask_q;
  logic [31:0]  out_next32;
  assign out_next32 = merge_masked(widen(out_q), bus_wdata, widen(mask_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      mask_q <= '1;
    end else begin
      if (wr_dir)  dir_q  <= wdata_w;
      if (wr_data) out_q  <= out_next32[W-1:0];
      if (wr_ien)  ien_q  <= wdata_w;
      if (wr_mask) mask_q <= wdata_w;
    end
  end

  // pin capture and change status
  logic [W-1:0] sync_vec, edge_vec, clr_vec, chg_vec;
  assign clr_vec = (bus_we && sel_chg) ? wdata_w : '0;

  gpio_line_sync #(.WIDTH(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sync_o (sync_vec),
    .edge_o (edge_vec)
  );

  gpio_change_status #(.WIDTH(W)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .edge_i(edge_vec),
    .clr_i (clr_vec),
    .chg_o (chg_vec)
  );

  // outputs
  logic [W-1:0] pending_vec;
  assign pending_vec = chg_vec & ien_q;
  assign irq     = |pending_vec;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  logic [31:0] view32;
  assign view32 = line_view(widen(dir_q), widen(out_q), widen(sync_vec));

  always_comb begin
    bus_rdata = '0;
    if (sel_dir)  bus_rdata = widen(dir_q);
    if (sel_data) bus_rdata = view32;
    if (sel_ien)  bus_rdata = widen(ien_q);
    if (sel_chg)  bus_rdata = widen(chg_vec);
    if (sel_mask) bus_rdata = widen(mask_q);
    if (sel_type) bus_rdata = TRIG_BOTH_CODE;
  end

  // direction write reaches the output enables next cycle (R2)
  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(wdata_w));
  // masked latch update (R3)
  assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> pin_out == (($past(pin_out) & ~$past(mask_q)) | ($past(wdata_w) & $past(mask_q))));
  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pin_out));
  // interrupt rises only with an enabled pending change (R8)
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0 && chg_vec != '0));
  // unimplemented positions read zero (R9)
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_type |-> (bus_rdata & ~LINE_MASK32) == '0);

endmodule

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_bench;

  localparam int NL = 12;
  localparam logic [31:0] LM = 32'h0000_0FFF;
  localparam logic [7:0] A_DIR = 8'h00, A_DATA = 8'h04, A_IEN = 8'h08,
                         A_CHG = 8'h0C, A_MASK = 8'h10, A_TYPE = 8'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic          irq;

  always #10 clk = ~clk;   // 50 MHz

  gpio_edge_ctrl #(.NUM_LINES(NL), .ADDR_W(8)) u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;

  // bench model
  logic [31:0] m_dir, m_out, m_ien, m_chg, m_mask, m_pins;

  function automatic logic [31:0] exp_view();
    return ((m_dir & m_out) | (~m_dir & m_pins)) & LM;
  endfunction

  function automatic logic exp_irq();
    return (m_chg & m_ien & LM) != 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    logic [31:0] old;
    old = m_pins;
    @(negedge clk);
    pin_in = v[NL-1:0];
    m_pins = v & LM;
    repeat (4) @(negedge clk);
    m_chg = m_chg | ((old ^ m_pins) & LM);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    bus_read(A_DIR, r);  check({tag, " R2 dir"}, r, m_dir);
    bus_read(A_DATA, r); check({tag, " R4 view"}, r, exp_view());
    bus_read(A_IEN, r);  check({tag, " R2 ien"}, r, m_ien);
    bus_read(A_CHG, r);  check({tag, " R5 chg"}, r, m_chg);
    bus_read(A_MASK, r); check({tag, " R3 mask"}, r, m_mask);
    bus_read(A_TYPE, r); check({tag, " R10 type"}, r, 32'h3);
    check({tag, " R3 pin_out"}, 32'(pin_out), m_out);
    check({tag, " R2 pin_oe"}, 32'(pin_oe), m_dir);
    check({tag, " R8 irq"}, 32'(irq), 32'(exp_irq()));
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m_dir = 0; m_out = 0; m_ien = 0; m_chg = 0; m_mask = LM; m_pins = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("reset R1");

    // R2 / R9 readback with upper bits ignored
    bus_write(A_DIR, 32'hFFFF_F0A5); m_dir = 32'hFFFF_F0A5 & LM;
    bus_read(A_DIR, r); check("R9 dir upper zero", r, 32'h0000_00A5);
    bus_write(A_IEN, 32'hFFFF_FFFF); m_ien = LM;
    bus_read(A_IEN, r); check("R9 ien upper zero", r, LM);

    // R3 masked data write
    bus_write(A_MASK, 32'h0000_00F0); m_mask = 32'h0F0;
    bus_write(A_DATA, 32'hFFFF_FFFF); m_out = 32'h0F0;
    check("R3 masked write", 32'(pin_out), 32'h0F0);
    bus_write(A_MASK, 32'hFFFF_FFFF); m_mask = LM;
    bus_write(A_DATA, 32'h0000_0A0F); m_out = 32'hA0F;
    check("R3 full write", 32'(pin_out), 32'hA0F);

    // R4 input latency: input line 1 (dir bit1 = 0)
    bus_write(A_DIR, 32'h0); m_dir = 0;
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk); bus_read(A_DATA, r); check("R4 one edge old", r & 32'h2, 32'h0);
    @(negedge clk); bus_read(A_DATA, r); check("R4 two edges new", r & 32'h2, 32'h2);
    bus_read(A_CHG, r); check("R5 not yet at two edges", r & 32'h2, 32'h0);
    @(negedge clk); bus_read(A_CHG, r); check("R5 set at third edge", r & 32'h2, 32'h2);
    check("R8 irq with enabled change", 32'(irq), 32'h1);
    m_pins = 32'h2; m_chg = 32'h2;

    // R6 clear, and write 0 leaves
    bus_write(A_CHG, 32'h0); bus_read(A_CHG, r); check("R6 zero write keeps", r, 32'h2);
    bus_write(A_CHG, 32'h2); m_chg = 0;
    bus_read(A_CHG, r); check("R6 one write clears", r, 32'h0);
    check("R8 irq low after clear", 32'(irq), 32'h0);

    // R5 falling edge while masked
    bus_write(A_IEN, 32'h0); m_ien = 0;
    set_pins(32'h0);
    bus_read(A_CHG, r); check("R5 falling edge latched while masked", r, 32'h2);
    check("R8 masked no irq", 32'(irq), 32'h0);
    bus_write(A_IEN, 32'h2); m_ien = 32'h2;
    check("R8 unmask raises irq", 32'(irq), 32'h1);

    // R7 edge vs clear in the same cycle (bit1 already set)
    @(negedge clk); pin_in[1] = 1'b1; m_pins = 32'h2;
    @(negedge clk);
    @(negedge clk); bus_addr = A_CHG; bus_we = 1'b1; bus_wdata = 32'h2;
    @(negedge clk); bus_we = 1'b0;
    bus_read(A_CHG, r); check("R7 edge wins over clear", r & 32'h2, 32'h2);
    repeat (3) @(negedge clk);
    bus_write(A_CHG, LM); m_chg = 0;
    bus_read(A_CHG, r); check("R7 later clear works", r, 32'h0);

    // R10 type ignores writes, R11 unmapped
    bus_write(A_TYPE, 32'h0); bus_read(A_TYPE, r); check("R10 type constant", r, 32'h3);
    bus_write(8'h18, 32'hFFFF_FFFF); bus_read(8'h18, r); check("R11 unmapped reads zero", r, 32'h0);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    check_all("R11 unmapped writes ignored");

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 8);
      d = $urandom;
      case (op)
        0: begin bus_write(A_DIR, d);  m_dir = d & LM; end
        1: begin bus_write(A_DATA, d); m_out = ((m_out & ~m_mask) | (d & m_mask)) & LM; end
        2: begin bus_write(A_IEN, d);  m_ien = d & LM; end
        3: begin bus_write(A_MASK, d); m_mask = d & LM; end
        4: begin bus_write(A_CHG, d);  m_chg = m_chg & ~d & LM; end
        5, 6: set_pins(d);
        default: begin
          if ($urandom % 2 == 0) bus_write(A_TYPE, d);
          else bus_write(8'h18 + 8'(4 * ($urandom % 10)), d);
        end
      endcase
      check_all("random R2 R3 R4 R5 R6 R8 R9");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule